// File: doc/BRIEF.md
# Thermal Monitor Register Bank

This block is the register file that sits behind a temperature monitor. A host path writes 16-bit words by register index and reads 16-bit words by index through a separate read index that returns data in the same cycle. The bank holds a capabilities word, a configuration word, three temperature limits (high, low and critical), the most recent temperature word with its status flags, two fixed identification words and a resolution register.

The configuration word carries two sticky lock bits. Only reset clears them. While a lock is set, it shields limit registers and selected configuration fields from writes. A shutdown request can be dropped at any time but can be raised only while both locks are clear. A write-only release command becomes a single-cycle pulse towards the event logic. The configuration fields, limits and resolution code are driven out as ports for the comparison and event logic, which is outside this block. That logic also supplies the temperature word and the event-active status.

Top module: `thermreg_bank`

## Requirements
- R1: After reset the reads are: index 0 = 0x0077, index 1 = 0x0000 (with evt_active low), indices 2, 3 and 4 = 0x0000, index 6 = 0x00B3, index 7 = 0x2913 and index 8 = 0x0010. The resolution code resets to binary 10.
- R2: Writes to indices 0, 5, 6 and 7, and to any index of 9 or above, change nothing. Reads of index 9 or above return 0. Index 5 returns the temp_word captured on the most recent clock with temp_vld high.
- R3: Configuration bit 7 (critical lock) and bit 6 (event lock) are set by writing 1. Writing 0 never clears them, and only reset does.
- R4: A write to index 4 (critical limit) is ignored while the critical lock is set. The lock value used is the one held before that write.
- R5: Writes to index 2 (high limit) and index 3 (low limit) are ignored while the event lock is set.
- R6: While either lock is set, the hysteresis field (config bits 10:9) and the event-enable bit (bit 3) keep their value. While the event lock is set, the critical-only bit (bit 2) keeps its value.
- R7: A write with shutdown (config bit 8) at 0 always clears shutdown. A write with bit 8 at 1 sets it only if neither lock was set before that write.
- R8: A config write with bit 5 at 1 makes clr_req high for exactly the one cycle after the write. Bit 5 always reads 0, and bit 4 reads the evt_active input.
- R9: Config bits 15:11 and capabilities bits 15:8 always read 0.
- R10: Index 8 stores a 2-bit resolution code from write bits 4:3. Index 8 reads it at bits 4:3 with all other bits 0, and capabilities bits 4:3 show the same code.
- R11: Limit registers keep write bits 12:2 (two's complement, 0.25 degree steps). Bits 15:13 and 1:0 read 0.
- R12: Config bit 1 (event polarity) and bit 0 (event mode) are always writable and drive evt_pol and evt_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Register index of the write |
| wr_data | input | 16 | Write word |
| rd_idx | input | 4 | Register index of the read |
| rd_data | output | 16 | Read word for rd_idx, same cycle |
| temp_vld | input | 1 | Capture temp_word this clock |
| temp_word | input | 16 | Temperature word with status flags |
| evt_active | input | 1 | Event output currently asserted |
| clr_req | output | 1 | One-cycle event release request |
| hyst_sel | output | 2 | Hysteresis selection |
| shdn | output | 1 | Shutdown request |
| evt_en | output | 1 | Event output enable |
| crit_only | output | 1 | Event only on critical limit |
| evt_pol | output | 1 | Event polarity, 1 = active high |
| evt_mode | output | 1 | Event mode, 1 = interrupt |
| crit_lock | output | 1 | Critical lock state |
| evt_lock | output | 1 | Event lock state |
| hi_lim | output | 11 | High limit, bits 12:2 of the word |
| lo_lim | output | 11 | Low limit, bits 12:2 of the word |
| crit_lim | output | 11 | Critical limit, bits 12:2 of the word |
| res_code | output | 2 | Resolution code |

## Verification
The assertions assume that synchronous reset is held for at least one clock before first use. They also assume that wr_idx, rd_idx and wr_data are never unknown while the bank is out of reset, because the lock and pulse properties look one cycle back at those inputs. The stimulus drives every input to a known value from time zero and changes inputs only on the falling clock edge. Its directed part sets the locks in a fixed order so that each gated field is tried both before and after locking. A random phase follows, with resets between its parts.

// File: rtl/thermreg_pkg.sv
package thermreg_pkg;
   localparam int unsigned IDX_W = 4;

   typedef enum logic [IDX_W-1:0] {
      IX_CAP  = 4'd0,
      IX_CFG  = 4'd1,
      IX_HI   = 4'd2,
      IX_LO   = 4'd3,
      IX_CRIT = 4'd4,
      IX_TEMP = 4'd5,
      IX_MFR  = 4'd6,
      IX_DEV  = 4'd7,
      IX_RES  = 4'd8
   } reg_idx_e;

   // configuration word bit positions
   localparam int unsigned CB_MODE   = 0;
   localparam int unsigned CB_POL    = 1;
   localparam int unsigned CB_CONLY  = 2;
   localparam int unsigned CB_EN     = 3;
   localparam int unsigned CB_STS    = 4;
   localparam int unsigned CB_CLR    = 5;
   localparam int unsigned CB_ELOCK  = 6;
   localparam int unsigned CB_CLOCK  = 7;
   localparam int unsigned CB_SHDN   = 8;
   localparam int unsigned CB_HYST   = 9;
   localparam int unsigned HYST_W    = 2;

   typedef struct packed {
      logic [HYST_W-1:0] hyst;
      logic              shdn;
      logic              clock;
      logic              elock;
      logic              en;
      logic              conly;
      logic              pol;
      logic              mode;
   } cfg_t;
endpackage

// File: rtl/thermreg_cfg.sv
module thermreg_cfg
   import thermreg_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wd,
   output cfg_t              cfg,
   output logic              clr_req
);
   cfg_t nxt;
   logic any_lock;

   assign any_lock = cfg.clock | cfg.elock;

   always_comb begin
      nxt = cfg;
      if (we) begin
         nxt.clock = cfg.clock | wd[CB_CLOCK];
         nxt.elock = cfg.elock | wd[CB_ELOCK];
         if (!any_lock) begin
            nxt.hyst = wd[CB_HYST +: HYST_W];
            nxt.en   = wd[CB_EN];
         end
         if (!cfg.elock) nxt.conly = wd[CB_CONLY];
         nxt.pol  = wd[CB_POL];
         nxt.mode = wd[CB_MODE];
         if (!wd[CB_SHDN])  nxt.shdn = 1'b0;
         else if (!any_lock) nxt.shdn = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg     <= '0;
         clr_req <= 1'b0;
      end else begin
         cfg     <= nxt;
         clr_req <= we & wd[CB_CLR];
      end
   end
endmodule

// File: rtl/thermreg_limit.sv
module thermreg_limit #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned LIM_MSB = 12,
   parameter int unsigned LIM_LSB = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic                       lock,
   input  logic [DATA_W-1:0]          wd,
   output logic [LIM_MSB-LIM_LSB:0]   lim
);
   always_ff @(posedge clk) begin
      if (!rst_n)          lim <= '0;
      else if (we && !lock) lim <= wd[LIM_MSB:LIM_LSB];
   end
endmodule

// File: rtl/thermreg_rdmux.sv
module thermreg_rdmux
   import thermreg_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned LIM_MSB = 12,
   parameter int unsigned LIM_LSB = 2,
   parameter int unsigned RES_W   = 2,
   parameter int unsigned RES_LSB = 3,
   parameter logic [DATA_W-1:0] MFR_ID  = 16'h00B3,
   parameter logic [DATA_W-1:0] DEV_REV = 16'h2913
) (
   input  logic [IDX_W-1:0]          rd_idx,
   input  cfg_t                      cfg,
   input  logic                      evt_active,
   input  logic [LIM_MSB-LIM_LSB:0]  hi_lim,
   input  logic [LIM_MSB-LIM_LSB:0]  lo_lim,
   input  logic [LIM_MSB-LIM_LSB:0]  crit_lim,
   input  logic [DATA_W-1:0]         temp_q,
   input  logic [RES_W-1:0]          res_q,
   output logic [DATA_W-1:0]         rd_data
);
   logic [DATA_W-1:0] cap_w, cfg_w, res_w, hi_w, lo_w, crit_w;

   always_comb begin
      cap_w = '0;
      cap_w[0] = 1'b1;
      cap_w[1] = 1'b1;
      cap_w[2] = 1'b1;
      cap_w[5] = 1'b1;
      cap_w[6] = 1'b1;
      cap_w[RES_LSB +: RES_W] = res_q;

      cfg_w = '0;
      cfg_w[CB_HYST +: HYST_W] = cfg.hyst;
      cfg_w[CB_SHDN]  = cfg.shdn;
      cfg_w[CB_CLOCK] = cfg.clock;
      cfg_w[CB_ELOCK] = cfg.elock;
      cfg_w[CB_STS]   = evt_active;
      cfg_w[CB_EN]    = cfg.en;
      cfg_w[CB_CONLY] = cfg.conly;
      cfg_w[CB_POL]   = cfg.pol;
      cfg_w[CB_MODE]  = cfg.mode;

      res_w = '0;
      res_w[RES_LSB +: RES_W] = res_q;

      hi_w = '0;   hi_w[LIM_MSB:LIM_LSB]   = hi_lim;
      lo_w = '0;   lo_w[LIM_MSB:LIM_LSB]   = lo_lim;
      crit_w = '0; crit_w[LIM_MSB:LIM_LSB] = crit_lim;

      case (rd_idx)
         IX_CAP:  rd_data = cap_w;
         IX_CFG:  rd_data = cfg_w;
         IX_HI:   rd_data = hi_w;
         IX_LO:   rd_data = lo_w;
         IX_CRIT: rd_data = crit_w;
         IX_TEMP: rd_data = temp_q;
         IX_MFR:  rd_data = MFR_ID;
         IX_DEV:  rd_data = DEV_REV;
         IX_RES:  rd_data = res_w;
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/thermreg_bank.sv
module thermreg_bank
   import thermreg_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned LIM_MSB = 12,
   parameter int unsigned LIM_LSB = 2,
   parameter int unsigned RES_W   = 2,
   parameter int unsigned RES_LSB = 3,
   parameter logic [RES_W-1:0]  RES_RST = 2'b10,
   parameter logic [DATA_W-1:0] MFR_ID  = 16'h00B3,
   parameter logic [DATA_W-1:0] DEV_REV = 16'h2913
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [3:0]                wr_idx,
   input  logic [DATA_W-1:0]         wr_data,
   input  logic [3:0]                rd_idx,
   output logic [DATA_W-1:0]         rd_data,
   input  logic                      temp_vld,
   input  logic [DATA_W-1:0]         temp_word,
   input  logic                      evt_active,
   output logic                      clr_req,
   output logic [1:0]                hyst_sel,
   output logic                      shdn,
   output logic                      evt_en,
   output logic                      crit_only,
   output logic                      evt_pol,
   output logic                      evt_mode,
   output logic                      crit_lock,
   output logic                      evt_lock,
   output logic [LIM_MSB-LIM_LSB:0]  hi_lim,
   output logic [LIM_MSB-LIM_LSB:0]  lo_lim,
   output logic [LIM_MSB-LIM_LSB:0]  crit_lim,
   output logic [RES_W-1:0]          res_code
);
   localparam int unsigned LIM_W = LIM_MSB - LIM_LSB + 1;
   localparam int unsigned NLIM  = 3;

   if (LIM_MSB >= DATA_W || LIM_LSB > LIM_MSB) begin : g_bad_lim
      $error("limit field does not fit the data word");
   end
   if (RES_LSB + RES_W > 8) begin : g_bad_res
      $error("resolution field must sit in the low byte");
   end
   if (DATA_W <= CB_HYST + HYST_W) begin : g_bad_w
      $error("data word too narrow for the configuration fields");
   end

   cfg_t cfg;
   logic cfg_we;
   assign cfg_we = wr_en && (wr_idx == IX_CFG);

   thermreg_cfg #(.DATA_W(DATA_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .wd      (wr_data),
      .cfg     (cfg),
      .clr_req (clr_req)
   );

   logic [NLIM-1:0]  lim_we, lim_lock;
   logic [LIM_W-1:0] lim_q [NLIM];
   logic [IDX_W-1:0] lim_ix [NLIM];

   assign lim_ix[0] = IX_HI;
   assign lim_ix[1] = IX_LO;
   assign lim_ix[2] = IX_CRIT;
   assign lim_lock  = {cfg.clock, cfg.elock, cfg.elock};

   for (genvar g = 0; g < NLIM; g++) begin : g_lim
      assign lim_we[g] = wr_en && (wr_idx == lim_ix[g]);
      thermreg_limit #(
         .DATA_W (DATA_W),
         .LIM_MSB(LIM_MSB),
         .LIM_LSB(LIM_LSB)
      ) u_lim (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (lim_we[g]),
         .lock  (lim_lock[g]),
         .wd    (wr_data),
         .lim   (lim_q[g])
      );
   end

   logic [RES_W-1:0]  res_q;
   logic [DATA_W-1:0] temp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q  <= RES_RST;
         temp_q <= '0;
      end else begin
         if (wr_en && wr_idx == IX_RES) res_q <= wr_data[RES_LSB +: RES_W];
         if (temp_vld) temp_q <= temp_word;
      end
   end

   thermreg_rdmux #(
      .DATA_W (DATA_W),
      .LIM_MSB(LIM_MSB),
      .LIM_LSB(LIM_LSB),
      .RES_W  (RES_W),
      .RES_LSB(RES_LSB),
      .MFR_ID (MFR_ID),
      .DEV_REV(DEV_REV)
   ) u_rd (
      .rd_idx    (rd_idx),
      .cfg       (cfg),
      .evt_active(evt_active),
      .hi_lim    (lim_q[0]),
      .lo_lim    (lim_q[1]),
      .crit_lim  (lim_q[2]),
      .temp_q    (temp_q),
      .res_q     (res_q),
      .rd_data   (rd_data)
   );

   assign hyst_sel  = cfg.hyst;
   assign shdn      = cfg.shdn;
   assign evt_en    = cfg.en;
   assign crit_only = cfg.conly;
   assign evt_pol   = cfg.pol;
   assign evt_mode  = cfg.mode;
   assign crit_lock = cfg.clock;
   assign evt_lock  = cfg.elock;
   assign hi_lim    = lim_q[0];
   assign lo_lim    = lim_q[1];
   assign crit_lim  = lim_q[2];
   assign res_code  = res_q;
endmodule

// File: rtl/thermreg_chk.sv
module thermreg_chk #(
   parameter int unsigned LIM_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [3:0]       wr_idx,
   input logic [15:0]      wr_data,
   input logic [3:0]       rd_idx,
   input logic [15:0]      rd_data,
   input logic             clr_req,
   input logic [1:0]       hyst_sel,
   input logic             shdn,
   input logic             evt_en,
   input logic             crit_only,
   input logic             crit_lock,
   input logic             evt_lock,
   input logic [LIM_W-1:0] hi_lim,
   input logic [LIM_W-1:0] lo_lim,
   input logic [LIM_W-1:0] crit_lim
);
   a_r3_crit_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      crit_lock |=> crit_lock);
   a_r3_evt_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      evt_lock |=> evt_lock);
   a_r4_crit_limit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      crit_lock |=> $stable(crit_lim));
   a_r5_window_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      evt_lock |=> ($stable(hi_lim) && $stable(lo_lim)));
   a_r6_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (crit_lock || evt_lock) |=> ($stable(hyst_sel) && $stable(evt_en)));
   a_r6_conly_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      evt_lock |=> $stable(crit_only));
   a_r7_no_shdn_set: assert property (@(posedge clk) disable iff (!rst_n)
      ((crit_lock || evt_lock) && !shdn) |=> !shdn);
   a_r8_clr_source: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |-> $past(wr_en && wr_idx == 4'd1 && wr_data[5]));
   a_r9_cfg_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx == 4'd1) |-> (rd_data[15:11] == 5'd0 && rd_data[5] == 1'b0));
   a_r11_limit_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx >= 4'd2 && rd_idx <= 4'd4) |-> (rd_data[15:13] == 3'd0 && rd_data[1:0] == 2'd0));
endmodule

bind thermreg_bank thermreg_chk #(.LIM_W(LIM_MSB - LIM_LSB + 1)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_idx    (wr_idx),
   .wr_data   (wr_data),
   .rd_idx    (rd_idx),
   .rd_data   (rd_data),
   .clr_req   (clr_req),
   .hyst_sel  (hyst_sel),
   .shdn      (shdn),
   .evt_en    (evt_en),
   .crit_only (crit_only),
   .crit_lock (crit_lock),
   .evt_lock  (evt_lock),
   .hi_lim    (hi_lim),
   .lo_lim    (lo_lim),
   .crit_lim  (crit_lim)
);

// File: tb/thermreg_bank_tb.sv
`timescale 1ns/1ps
module thermreg_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [15:0] wr_data = '0;
   logic [3:0]  rd_idx = '0;
   logic [15:0] rd_data;
   logic        temp_vld = 1'b0;
   logic [15:0] temp_word = '0;
   logic        evt_active = 1'b0;
   logic        clr_req, shdn, evt_en, crit_only, evt_pol, evt_mode, crit_lock, evt_lock;
   logic [1:0]  hyst_sel, res_code;
   logic [10:0] hi_lim, lo_lim, crit_lim;

   always #10 clk = ~clk;

   thermreg_bank u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data), .temp_vld(temp_vld), .temp_word(temp_word),
      .evt_active(evt_active), .clr_req(clr_req), .hyst_sel(hyst_sel), .shdn(shdn),
      .evt_en(evt_en), .crit_only(crit_only), .evt_pol(evt_pol), .evt_mode(evt_mode),
      .crit_lock(crit_lock), .evt_lock(evt_lock), .hi_lim(hi_lim), .lo_lim(lo_lim),
      .crit_lim(crit_lim), .res_code(res_code)
   );

   int errors = 0;
   int checks = 0;

   // reference model state
   logic [15:0] m_cfg, m_hi, m_lo, m_crit, m_temp;
   logic [1:0]  m_res;
   logic        m_clr;

   task automatic model_reset();
      m_cfg = 16'h0000; m_hi = 16'h0; m_lo = 16'h0; m_crit = 16'h0;
      m_temp = 16'h0; m_res = 2'b10; m_clr = 1'b0;
   endtask

   task automatic model_write(input logic we, input logic [3:0] wi, input logic [15:0] wd);
      bit locked;
      m_clr = 1'b0;
      if (!we) return;
      locked = m_cfg[7] || m_cfg[6];
      case (wi)
         4'd1: begin
            logic [15:0] n;
            n = m_cfg;
            if (wd[7]) n[7] = 1'b1;
            if (wd[6]) n[6] = 1'b1;
            if (!locked) begin n[10:9] = wd[10:9]; n[3] = wd[3]; end
            if (!m_cfg[6]) n[2] = wd[2];
            n[1] = wd[1]; n[0] = wd[0];
            if (wd[8] == 1'b0) n[8] = 1'b0;
            else if (!locked)  n[8] = 1'b1;
            m_cfg = n;
            m_clr = wd[5];
         end
         4'd2: if (!m_cfg[6]) m_hi = wd & 16'h1FFC;
         4'd3: if (!m_cfg[6]) m_lo = wd & 16'h1FFC;
         4'd4: if (!m_cfg[7]) m_crit = wd & 16'h1FFC;
         4'd8: m_res = wd[4:3];
         default: ;
      endcase
   endtask

   function automatic logic [15:0] exp_read(input logic [3:0] idx);
      case (idx)
         4'd0: return 16'h0067 | (16'(m_res) << 3);
         4'd1: return (m_cfg & 16'h07CF) | (16'(evt_active) << 4);
         4'd2: return m_hi;
         4'd3: return m_lo;
         4'd4: return m_crit;
         4'd5: return m_temp;
         4'd6: return 16'h00B3;
         4'd7: return 16'h2913;
         4'd8: return 16'(m_res) << 3;
         default: return 16'h0000;
      endcase
   endfunction

   task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic compare(input string req);
      logic [63:0] got_o, exp_o;
      check(req, "rd_data", 64'(rd_data), 64'(exp_read(rd_idx)));
      got_o = {clr_req, hyst_sel, shdn, crit_lock, evt_lock, evt_en, crit_only,
               evt_pol, evt_mode, hi_lim, lo_lim, crit_lim, res_code};
      exp_o = {m_clr, m_cfg[10:9], m_cfg[8], m_cfg[7], m_cfg[6], m_cfg[3], m_cfg[2],
               m_cfg[1], m_cfg[0], m_hi[12:2], m_lo[12:2], m_crit[12:2], m_res};
      check(req, "outputs", got_o, exp_o);
   endtask

   // called at a falling edge; ends at the next falling edge
   task automatic step(input string req, input logic we, input logic [3:0] wi,
                       input logic [15:0] wd, input logic [3:0] ri);
      wr_en = we; wr_idx = wi; wr_data = wd; rd_idx = ri;
      @(posedge clk);
      model_write(we, wi, wd);
      if (temp_vld) m_temp = temp_word;
      @(negedge clk);
      wr_en = 1'b0; temp_vld = 1'b0;
      compare(req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; temp_vld = 1'b0;
      repeat (2) @(negedge clk);
      model_reset();
      rst_n = 1'b1;
   endtask

   initial begin
      model_reset();
      do_reset();
      // R1: reset values across every index
      for (int i = 0; i < 10; i++) step("R1", 1'b0, 4'd0, 16'h0, 4'(i));

      // R11: limits keep bits 12:2 only
      step("R11", 1'b1, 4'd2, 16'hFFFF, 4'd2);
      step("R11", 1'b1, 4'd3, 16'h0193, 4'd3);
      step("R11", 1'b1, 4'd4, 16'hE551, 4'd4);

      // R2: read-only and out-of-range indices
      step("R2", 1'b1, 4'd0, 16'hFFFF, 4'd0);
      step("R2", 1'b1, 4'd5, 16'hFFFF, 4'd5);
      step("R2", 1'b1, 4'd6, 16'hFFFF, 4'd6);
      step("R2", 1'b1, 4'd7, 16'h0000, 4'd7);
      step("R2", 1'b1, 4'd9, 16'hFFFF, 4'd9);
      step("R2", 1'b1, 4'd15, 16'hFFFF, 4'd15);
      temp_vld = 1'b1; temp_word = 16'hC123;
      step("R2", 1'b0, 4'd0, 16'h0, 4'd5);
      temp_word = 16'h1111;
      step("R2", 1'b0, 4'd0, 16'h0, 4'd5);

      // R10: resolution register and its mirror
      step("R10", 1'b1, 4'd8, 16'hFFFF, 4'd8);
      step("R10", 1'b0, 4'd0, 16'h0, 4'd0);
      step("R10", 1'b1, 4'd8, 16'h0000, 4'd0);
      step("R10", 1'b1, 4'd8, 16'h0010, 4'd8);

      // R8: clear pulse, bit 5 reads 0, bit 4 follows evt_active
      step("R8", 1'b1, 4'd1, 16'h0623, 4'd1);
      step("R8", 1'b0, 4'd0, 16'h0, 4'd1);
      evt_active = 1'b1;
      step("R8", 1'b0, 4'd0, 16'h0, 4'd1);
      evt_active = 1'b0;

      // R9: upper configuration bits read 0; R12 polarity and mode
      step("R9", 1'b1, 4'd1, 16'hF90F, 4'd1);
      step("R12", 1'b1, 4'd1, 16'h0102, 4'd1);

      // R3 / R7: set event lock while shutdown is on, then clear shutdown
      step("R3", 1'b1, 4'd1, 16'h0140, 4'd1);
      step("R3", 1'b1, 4'd1, 16'h0100, 4'd1);
      step("R7", 1'b1, 4'd1, 16'h0000, 4'd1);
      step("R7", 1'b1, 4'd1, 16'h0100, 4'd1);

      // R6: locked fields
      step("R6", 1'b1, 4'd1, 16'h060D, 4'd1);
      step("R12", 1'b1, 4'd1, 16'h0001, 4'd1);

      // R5: window limits locked, R4 critical limit still open
      step("R5", 1'b1, 4'd2, 16'h0AAC, 4'd2);
      step("R5", 1'b1, 4'd3, 16'h0554, 4'd3);
      step("R4", 1'b1, 4'd4, 16'h0320, 4'd4);

      // R4: set critical lock, then critical writes are dropped
      step("R4", 1'b1, 4'd1, 16'h0080, 4'd1);
      step("R4", 1'b1, 4'd4, 16'h1FFC, 4'd4);
      step("R3", 1'b1, 4'd1, 16'h0000, 4'd1);

      // R6: critical lock alone blocks hysteresis and enable but not crit_only
      do_reset();
      step("R6", 1'b1, 4'd1, 16'h0088, 4'd1);
      step("R6", 1'b1, 4'd1, 16'h0604, 4'd1);
      step("R6", 1'b1, 4'd1, 16'h0000, 4'd1);
      step("R5", 1'b1, 4'd2, 16'h0AAC, 4'd2);

      // mixed random traffic with periodic resets
      for (int p = 0; p < 4; p++) begin
         do_reset();
         for (int k = 0; k < 150; k++) begin
            logic [15:0] d;
            logic [3:0]  wi;
            d  = 16'($urandom);
            wi = 4'($urandom_range(0, 10));
            if (wi == 4'd1 && ($urandom_range(0, 3) != 0)) d[7:6] = 2'b00;
            evt_active = 1'($urandom);
            temp_vld   = ($urandom_range(0, 5) == 0);
            temp_word  = 16'($urandom);
            step("R2", 1'($urandom_range(0, 3) != 0), wi, d, 4'($urandom_range(0, 10)));
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule